// File: doc/BRIEF.md
# Dual-Convention Register Slave Port

This block gives a host processor read and write access to a bank of 64 sixteen-bit registers held inside a peripheral. The host presents an active-low chip select, an address strobe, a data strobe, a direction line and a six-bit register index. A static mode input selects one of two host bus styles. The two styles differ in the address strobe edge that captures the index, in the polarity of the direction line, and in the signal that ends each access.

All host strobes are asynchronous to the bus clock. Each one passes through a two-flop synchronizer, and edges are detected on the synchronized copies. Read data appears on the low sixteen lines of a 32-bit path. The upper lines read as zero, and accesses of a narrower size are not supported. The peripheral also has an internal master request. The port treats that request as a guard: chip select must stay clear of it. When a host access arrives too close to the request, the access is flagged and is never terminated.

Top module: `regport_top`

## Requirements
- R1: While reset is applied and just after it, both acknowledge lines are high, the ready output is low, neither output enable is set and the violation flag is low.
- R2: With `busMode`=0 the register index is taken on the rising edge of `addrStb`. With `busMode`=1 it is taken on the falling edge. An index that is present only at the other edge has no effect.
- R3: With `busMode`=1, `rdWr` high means a read and low means a write. With `busMode`=0 the meaning is reversed: low is a read and high is a write.
- R4: A write stores `wrData` into the indexed register. A later read of that index returns the value on `rdData[15:0]` while `dataOe` is high, with `rdData[31:16]` at zero.
- R5: With `busMode`=1 an access ends with both `ackN` lines low together, and `readyOut` stays low. With `busMode`=0 it ends with `readyOut` high, and `ackN` stays at 2'b11.
- R6: While the synchronized chip select is inactive, `ackOe` and `dataOe` are low. `ackOe` is high only with `busMode`=1 and chip select active.
- R7: `violation` is raised if chip select becomes active while `mstReq` is high, or fewer than two clocks after `mstReq` falls. It is also raised if `mstReq` rises during an access. A flagged access writes nothing and is not terminated. The flag clears when chip select is released.
- R8: Termination, and the read data with it, stays asserted and stable while the data strobe is held. Termination drops within a few clocks of the data strobe's release.
- R9: All 64 indices, from 0 to 63, address independent storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMode | input | 1 | Static bus-style select (0 or 1) |
| csN | input | 1 | Active-low chip select from host |
| addrStb | input | 1 | Address strobe from host |
| dataStb | input | 1 | Data strobe from host, active high |
| rdWr | input | 1 | Direction line, polarity set by `busMode` |
| regAddr | input | 6 | Register index |
| wrData | input | 16 | Write data from host lines 15..0 |
| mstReq | input | 1 | Internal master request, used as a guard |
| rdData | output | 32 | Read data, bits 31..16 always zero |
| dataOe | output | 1 | Drive enable for `rdData[15:0]` |
| ackN | output | 2 | Active-low acknowledge pair (`busMode`=1) |
| ackOe | output | 1 | Drive enable for `ackN` |
| readyOut | output | 1 | Ready termination (`busMode`=0) |
| violation | output | 1 | Chip select and master request spacing fault |

## Verification
A vector table runs writes and reads alternately in both modes against the same registers. A value written in one style and read back in the other confirms that both the direction polarity and the index capture agree across modes. In every access the index line carries a decoy value at the edge that should be ignored. A read of the decoy register then shows which strobe edge actually captured the index. Directed cases space chip select at one clock and at six clocks after the master request falls. This separates a flagged access, which leaves the register unwritten, from a legal access. A further case overlaps the master request with an open access.

// File: rtl/regport_pkg.sv
package regport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TERM
  } phase_t;

  typedef struct packed {
    logic csAct;
    logic latchAddr;
    logic doWrite;
    logic doRead;
    logic term;
  } ctrlStb_t;

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int GAP_CYC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     busMode,
  input  logic     csN,
  input  logic     addrStb,
  input  logic     dataStb,
  input  logic     rdWr,
  input  logic     mstReq,
  output ctrlStb_t stb,
  output logic     violation
);

  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(GAP_CYC);

  logic [3:0] rawIn;
  logic [3:0] syncIn;
  logic       mstSync;

  assign rawIn = {~csN, addrStb, dataStb, rdWr};

  regport_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) uSyncBus (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  // master request is delayed by the same depth so both sides line up
  regport_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uSyncMst (
    .clk  (clk),
    .rstN (rstN),
    .din  (mstReq),
    .dout (mstSync)
  );

  logic csAct, asLvl, dsLvl, rwLvl;
  assign {csAct, asLvl, dsLvl, rwLvl} = syncIn;

  logic csPrev, asPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev <= 1'b0;
      asPrev <= 1'b0;
    end else begin
      csPrev <= csAct;
      asPrev <= asLvl;
    end
  end

  logic csRise, asRise, asFall, addrEdge, hostRead;
  assign csRise   = csAct & ~csPrev;
  assign asRise   = asLvl & ~asPrev;
  assign asFall   = ~asLvl & asPrev;
  assign addrEdge = busMode ? asFall : asRise;
  assign hostRead = busMode ? rwLvl : ~rwLvl;

  // clocks elapsed since the master request dropped, saturating
  logic [GAP_W-1:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gapCnt <= GAP_LIM;
    else if (mstSync)        gapCnt <= '0;
    else if (gapCnt < GAP_LIM) gapCnt <= gapCnt + 1'b1;
  end

  logic violSet, violQ, blocked;
  assign violSet = (csRise & (mstSync | (gapCnt < GAP_LIM))) | (csAct & mstSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        violQ <= 1'b0;
    else if (!csAct)  violQ <= 1'b0;
    else if (violSet) violQ <= 1'b1;
  end

  assign blocked   = violQ | violSet;
  assign violation = violQ;

  phase_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt       = state;
    stb       = '0;
    stb.csAct = csAct;
    unique case (state)
      ST_IDLE: begin
        if (csAct && !blocked && addrEdge) begin
          stb.latchAddr = 1'b1;
          nxt           = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (!csAct || blocked) begin
          nxt = ST_IDLE;
        end else if (dsLvl) begin
          stb.doRead  = hostRead;
          stb.doWrite = ~hostRead;
          nxt         = ST_TERM;
        end
      end
      ST_TERM: begin
        stb.term = csAct & ~blocked;
        if (!csAct || !dsLvl || blocked) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/regport_dp.sv
module regport_dp
  import regport_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              dataOe,
  output logic [1:0]        ackN,
  output logic              ackOe,
  output logic              readyOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = BUS_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] regs [DEPTH];
  logic [DATA_W-1:0] rdQ;
  logic              rdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrQ <= '0;
    else if (stb.latchAddr) addrQ <= regAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (stb.doWrite) begin
      regs[addrQ] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ     <= '0;
      rdValid <= 1'b0;
    end else if (stb.doRead) begin
      rdQ     <= regs[addrQ];
      rdValid <= 1'b1;
    end else if (stb.doWrite) begin
      rdValid <= 1'b0;
    end
  end

  generate
    if (PAD_W > 0) begin : gPad
      assign rdData = {{PAD_W{1'b0}}, rdQ};
    end else begin : gNoPad
      assign rdData = rdQ[BUS_W-1:0];
    end
  endgenerate

  assign dataOe   = stb.term & rdValid;
  assign ackN     = (busMode && stb.term) ? 2'b00 : 2'b11;
  assign ackOe    = busMode & stb.csAct;
  assign readyOut = ~busMode & stb.term;

endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUS_W       = 32,
  parameter int GAP_CYC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  logic              csN,
  input  logic              addrStb,
  input  logic              dataStb,
  input  logic              rdWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mstReq,
  output logic [BUS_W-1:0]  rdData,
  output logic              dataOe,
  output logic [1:0]        ackN,
  output logic              ackOe,
  output logic              readyOut,
  output logic              violation
);

  ctrlStb_t ctrlStb;
  logic     csActive;

  regport_ctrl #(.GAP_CYC(GAP_CYC), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busMode   (busMode),
    .csN       (csN),
    .addrStb   (addrStb),
    .dataStb   (dataStb),
    .rdWr      (rdWr),
    .mstReq    (mstReq),
    .stb       (ctrlStb),
    .violation (violation)
  );

  regport_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .busMode  (busMode),
    .stb      (ctrlStb),
    .regAddr  (regAddr),
    .wrData   (wrData),
    .rdData   (rdData),
    .dataOe   (dataOe),
    .ackN     (ackN),
    .ackOe    (ackOe),
    .readyOut (readyOut)
  );

  assign csActive = ctrlStb.csAct;

endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busMode,
  input logic             csActive,
  input logic [1:0]       ackN,
  input logic             readyOut,
  input logic             ackOe,
  input logic             dataOe,
  input logic             violation,
  input logic [BUS_W-1:0] rdData
);

  p_ack_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackN == 2'b00) || (ackN == 2'b11));

  p_mode1_noready_r5: assert property (@(posedge clk) disable iff (!rstN)
    busMode |-> !readyOut);

  p_mode0_noack_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busMode |-> (ackN == 2'b11));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> (!ackOe && !dataOe && !readyOut && ackN == 2'b11));

  p_viol_noterm_r7: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (ackN == 2'b11 && !readyOut && !dataOe));

  p_read_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(rdData));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (rdData[BUS_W-1:DATA_W] == '0));

endmodule

bind regport_top regport_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busMode   (busMode),
  .csActive  (csActive),
  .ackN      (ackN),
  .readyOut  (readyOut),
  .ackOe     (ackOe),
  .dataOe    (dataOe),
  .violation (violation),
  .rdData    (rdData)
);

// File: tb/tb_regport_top.sv
`timescale 1ns/1ps
module tb_regport_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busMode = 1'b1;
  logic        csN = 1'b1;
  logic        addrStb = 1'b0;
  logic        dataStb = 1'b0;
  logic        rdWr = 1'b1;
  logic [5:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic        mstReq = 1'b0;
  logic [31:0] rdData;
  logic        dataOe;
  logic [1:0]  ackN;
  logic        ackOe;
  logic        readyOut;
  logic        violation;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  regport_top dut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .csN(csN), .addrStb(addrStb),
    .dataStb(dataStb), .rdWr(rdWr), .regAddr(regAddr), .wrData(wrData),
    .mstReq(mstReq), .rdData(rdData), .dataOe(dataOe), .ackN(ackN),
    .ackOe(ackOe), .readyOut(readyOut), .violation(violation)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finishRun();
  end

  function automatic bit termNow();
    return busMode ? (ackN == 2'b00) : readyOut;
  endfunction

  // one full host access; decoy index sits at the ignored strobe edge
  task automatic access(input logic m, input logic wr, input logic [5:0] a, input logic [15:0] d,
                        output logic [31:0] rd, output bit acked, output bit formOk,
                        output bit heldOk, output bit relOk, output bit oeSeen);
    busMode = m;
    rdWr    = m ? ~wr : wr;
    regAddr = m ? ~a : a;
    wrData  = d;
    csN     = 1'b0;
    repeat (4) @(negedge clk);
    addrStb = 1'b1;
    repeat (5) @(negedge clk);
    regAddr = m ? a : ~a;
    repeat (5) @(negedge clk);
    addrStb = 1'b0;
    repeat (5) @(negedge clk);
    dataStb = 1'b1;
    acked = 0;
    for (int i = 0; i < 30 && !acked; i++) begin
      @(negedge clk);
      if (termNow()) acked = 1;
    end
    formOk = m ? (!readyOut && ackOe) : (ackN == 2'b11 && !ackOe);
    repeat (3) @(negedge clk);
    heldOk = termNow();
    rd     = rdData;
    oeSeen = dataOe;
    dataStb = 1'b0;
    repeat (6) @(negedge clk);
    relOk = !termNow() && !dataOe;
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // fields: [23] mode, [22] write, [21:16] index, [15:0] data or expected read
  localparam logic [23:0] VEC [12] = '{
    {1'b1, 1'b1, 6'h05, 16'hA5A5},
    {1'b0, 1'b0, 6'h05, 16'hA5A5},
    {1'b0, 1'b1, 6'h3F, 16'h1234},
    {1'b1, 1'b0, 6'h3F, 16'h1234},
    {1'b1, 1'b1, 6'h00, 16'hFFFF},
    {1'b0, 1'b1, 6'h2A, 16'h0F0F},
    {1'b0, 1'b0, 6'h00, 16'hFFFF},
    {1'b1, 1'b0, 6'h2A, 16'h0F0F},
    {1'b1, 1'b0, 6'h15, 16'h0000},
    {1'b0, 1'b1, 6'h15, 16'hBEEF},
    {1'b0, 1'b0, 6'h2A, 16'h0F0F},
    {1'b1, 1'b0, 6'h15, 16'hBEEF}
  };

  initial begin
    logic [31:0] rd;
    bit acked, formOk, heldOk, relOk, oeSeen;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(ackN == 2'b11 && !readyOut && !dataOe && !ackOe && !violation, "R1 during reset",
          {27'b0, ackN, readyOut, dataOe, violation}, {27'b0, 2'b11, 3'b000});
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(ackN == 2'b11 && !readyOut && !dataOe && !ackOe && !violation, "R1 after reset",
          {27'b0, ackN, readyOut, dataOe, violation}, {27'b0, 2'b11, 3'b000});
    // R6: idle in mode 1 keeps the acknowledge enable low
    check(!ackOe, "R6 idle ackOe", {31'b0, ackOe}, 32'h0);

    for (int v = 0; v < 12; v++) begin
      access(VEC[v][23], VEC[v][22], VEC[v][21:16], VEC[v][15:0], rd, acked, formOk, heldOk, relOk, oeSeen);
      check(acked, $sformatf("R5 termination vec %0d", v), {31'b0, acked}, 32'h1);
      check(formOk, $sformatf("R5 R6 termination form vec %0d", v), {31'b0, formOk}, 32'h1);
      check(heldOk && relOk, $sformatf("R8 hold and release vec %0d", v),
            {30'b0, heldOk, relOk}, 32'h3);
      if (!VEC[v][22]) begin
        check(oeSeen && rd == {16'h0, VEC[v][15:0]},
              $sformatf("R2 R3 R4 R9 read vec %0d", v), rd, {16'h0, VEC[v][15:0]});
      end else begin
        check(!oeSeen, $sformatf("R3 write drives no data vec %0d", v), {31'b0, oeSeen}, 32'h0);
      end
    end

    // R7: chip select one clock after the master request drops
    busMode = 1'b1;
    mstReq = 1'b1;
    repeat (4) @(negedge clk);
    mstReq = 1'b0;
    @(negedge clk);
    rdWr = 1'b0; regAddr = 6'h10; wrData = 16'h7777; csN = 1'b0;
    repeat (5) @(negedge clk);
    check(violation, "R7 close spacing flag", {31'b0, violation}, 32'h1);
    addrStb = 1'b1; repeat (5) @(negedge clk);
    addrStb = 1'b0; repeat (5) @(negedge clk);
    dataStb = 1'b1;
    acked = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (termNow()) acked = 1;
    end
    check(!acked, "R7 flagged access not terminated", {31'b0, acked}, 32'h0);
    dataStb = 1'b0; repeat (3) @(negedge clk);
    csN = 1'b1; repeat (6) @(negedge clk);
    check(!violation, "R7 flag clears on release", {31'b0, violation}, 32'h0);
    access(1'b1, 1'b0, 6'h10, 16'h0, rd, acked, formOk, heldOk, relOk, oeSeen);
    check(acked && rd == 32'h0, "R7 flagged write stored nothing", rd, 32'h0);

    // R7: legal spacing of six clocks
    mstReq = 1'b1;
    repeat (4) @(negedge clk);
    mstReq = 1'b0;
    repeat (6) @(negedge clk);
    access(1'b0, 1'b1, 6'h10, 16'h4321, rd, acked, formOk, heldOk, relOk, oeSeen);
    check(acked && !violation, "R7 legal spacing accepted", {31'b0, acked}, 32'h1);
    access(1'b0, 1'b0, 6'h10, 16'h0, rd, acked, formOk, heldOk, relOk, oeSeen);
    check(rd == 32'h4321, "R4 R7 legal write stored", rd, 32'h4321);

    // R7: master request rising during an open access
    busMode = 1'b1; csN = 1'b0;
    repeat (5) @(negedge clk);
    mstReq = 1'b1;
    repeat (5) @(negedge clk);
    check(violation, "R7 overlap flag", {31'b0, violation}, 32'h1);
    mstReq = 1'b0; csN = 1'b1;
    repeat (8) @(negedge clk);
    check(!violation && !ackOe, "R6 R7 quiet after release", {30'b0, violation, ackOe}, 32'h0);

    finishRun();
  end

endmodule